// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block is the command path of a per-core interrupt controller in a multi-core chip. Software writes one interrupt command: a vector, a delivery mode, a trigger mode, a destination core and a two-bit destination shorthand. Depending on the shorthand, the block does one of three things. It can send a single interrupt message to the named core. It can raise the interrupt only on its own core, through a local request strobe. It can also send one message to every other core, and optionally raise the local request as well.

Every message that goes out is counted as in flight. The fabric returns one response for each message, and each response lowers the count. The delivery-status flag `busy` is high while the count is non-zero. A new command is refused until the block is idle again. The block has four states, held in an enumerated state register:

- `ST_IDLE` accepts a command.
- `ST_UNI` presents the single message.
- `ST_BCAST` walks core identifiers in ascending order, skipping its own.
- `ST_DRAIN` waits for the count to reach zero.

The transitions are:

- `ST_IDLE` goes to `ST_UNI` on an explicit-destination command.
- `ST_IDLE` goes to `ST_BCAST` on either broadcast shorthand.
- `ST_IDLE` stays in `ST_IDLE` on a self-only command.
- `ST_UNI` goes to `ST_DRAIN` when its message is taken.
- `ST_BCAST` goes to `ST_DRAIN` when its last message is taken.
- `ST_DRAIN` goes to `ST_IDLE` once no message is outstanding.

Top module: `ipi_dispatch`

## Requirements
- R1: Shorthand 0 (explicit destination) sends exactly one message to `cmd_dest`, carrying the command's vector, mode and trigger. `busy` is high from the cycle after acceptance.
- R2: Shorthand 1 (self only) pulses `lirq_valid` for one cycle, in the cycle after acceptance, with the command's vector, mode and trigger. It sends no message and leaves `busy` low.
- R3: Shorthand 2 (all including self) pulses `lirq_valid` in the cycle after acceptance and also performs the full broadcast of R4.
- R4: Shorthand 3 (all excluding self) sends NUM_CORES-1 messages, one per accepted handshake, to identifiers 0..NUM_CORES-1 in ascending order, skipping SELF_ID. It raises no local request.
- R5: `busy` stays high until the number of responses equals the number of messages sent. It drops in the cycle after the last response.
- R6: `cmd_ready` is high only in `ST_IDLE`. It is low while messages are being sent or while any message is outstanding.
- R7: A response that arrives while no message is outstanding does not change the count, so a later send still needs exactly one response per message. It also sets `rsp_err`, which stays high until reset.
- R8: After reset, `busy`, `rsp_err`, `msg_valid` and `lirq_valid` are low and `cmd_ready` is high.
- R9: While `msg_valid` is high and `msg_ready` is low, the message and its destination do not change.
- R10: A response in the same cycle as a message handshake is counted, so the count remains correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command write present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_short | input | 2 | Destination shorthand: 0 explicit, 1 self, 2 all incl. self, 3 all excl. self |
| cmd_dest | input | ID_W | Explicit destination core |
| cmd_vector | input | 8 | Interrupt vector |
| cmd_mode | input | 3 | Delivery mode |
| cmd_trig | input | 1 | Trigger mode |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Fabric takes the message |
| msg_dest | output | ID_W | Message destination core |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_trig | output | 1 | Message trigger mode |
| rsp_valid | input | 1 | One response from the fabric |
| lirq_valid | output | 1 | Local interrupt request strobe |
| lirq_vector | output | 8 | Local request vector |
| lirq_mode | output | 3 | Local request delivery mode |
| lirq_trig | output | 1 | Local request trigger mode |
| busy | output | 1 | Delivery status: messages in flight |
| rsp_err | output | 1 | Sticky: response with nothing outstanding |

## Verification
The risky coincidence is a fabric response arriving in the same cycle as an outgoing broadcast handshake. In that cycle the counter is both draining and, in effect, still being committed to. The bench raises `rsp_valid` exactly on the edge where the second broadcast message is taken. It then checks that `busy` survives one more response and falls after the next. A second coincidence is a stray response in idle: the bench checks that `rsp_err` sets, and that the following unicast still needs exactly one response.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int VEC_W  = 8;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        SH_DEST   = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } short_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UNI,
        ST_BCAST,
        ST_DRAIN
    } state_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [MODE_W-1:0] mode;
        logic              trig;
    } ipi_payload_t;
endpackage

// File: rtl/ipi_seq.sv
module ipi_seq
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SELF_ID   = 2,
    parameter int ID_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  short_e          cmd_short,
    input  logic [ID_W-1:0] cmd_dest,
    input  ipi_payload_t    cmd_pay,
    input  logic            msg_ready,
    input  logic            cnt_zero,
    output logic            cmd_ready,
    output logic            msg_valid,
    output logic [ID_W-1:0] msg_dest,
    output ipi_payload_t    msg_pay,
    output logic            add_one,
    output logic            add_bcast,
    output logic            lirq_fire
);
    localparam int FIRST_ID = (SELF_ID == 0) ? 1 : 0;
    localparam int LAST_ID  = (SELF_ID == NUM_CORES - 1) ? NUM_CORES - 2 : NUM_CORES - 1;
    localparam logic [ID_W-1:0] SELF_L  = ID_W'(SELF_ID);
    localparam logic [ID_W-1:0] FIRST_L = ID_W'(FIRST_ID);
    localparam logic [ID_W-1:0] LAST_L  = ID_W'(LAST_ID);

    state_e          state_q, state_d;
    logic [ID_W-1:0] idx_q, idx_d, idx_inc, idx_step;
    ipi_payload_t    pay_q, pay_d;
    logic            accept;

    assign accept = cmd_valid && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pay_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pay_q   <= pay_d;
        end
    end

    always_comb begin
        idx_inc  = idx_q + ID_W'(1);
        idx_step = (idx_inc == SELF_L) ? idx_inc + ID_W'(1) : idx_inc;
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        pay_d   = accept ? cmd_pay : pay_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cmd_short)
                        SH_DEST: begin
                            state_d = ST_UNI;
                            idx_d   = cmd_dest;
                        end
                        SH_SELF: state_d = ST_IDLE;
                        SH_ALL, SH_OTHERS: begin
                            state_d = ST_BCAST;
                            idx_d   = FIRST_L;
                        end
                    endcase
                end
            end
            ST_UNI: begin
                if (msg_ready) state_d = ST_DRAIN;
            end
            ST_BCAST: begin
                if (msg_ready) begin
                    if (idx_q == LAST_L) state_d = ST_DRAIN;
                    else                 idx_d   = idx_step;
                end
            end
            ST_DRAIN: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        msg_valid = (state_q == ST_UNI) || (state_q == ST_BCAST);
        msg_dest  = idx_q;
        msg_pay   = pay_q;
        add_one   = accept && (cmd_short == SH_DEST);
        add_bcast = accept && ((cmd_short == SH_ALL) || (cmd_short == SH_OTHERS));
        lirq_fire = accept && ((cmd_short == SH_SELF) || (cmd_short == SH_ALL));
    end
endmodule

// File: rtl/ipi_inflight.sv
module ipi_inflight #(
    parameter int NUM_CORES = 4,
    parameter int CNT_W     = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic add_one,
    input  logic add_bcast,
    input  logic rsp_valid,
    output logic busy,
    output logic cnt_zero,
    output logic rsp_err
);
    localparam logic [CNT_W-1:0] BCAST_ADD = CNT_W'(NUM_CORES - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             dec, stray, err_q;

    always_comb begin
        dec   = rsp_valid && (cnt_q != '0);
        stray = rsp_valid && (cnt_q == '0);
        cnt_d = cnt_q;
        if (add_one)   cnt_d = cnt_d + CNT_W'(1);
        if (add_bcast) cnt_d = cnt_d + BCAST_ADD;
        if (dec)       cnt_d = cnt_d - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            err_q <= err_q || stray;
        end
    end

    assign busy     = (cnt_q != '0);
    assign cnt_zero = (cnt_q == '0);
    assign rsp_err  = err_q;
endmodule

// File: rtl/ipi_local.sv
module ipi_local
    import ipi_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lirq_fire,
    input  ipi_payload_t cmd_pay,
    output logic         lirq_valid,
    output ipi_payload_t lirq_pay
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lirq_valid <= 1'b0;
            lirq_pay   <= '0;
        end else begin
            lirq_valid <= lirq_fire;
            if (lirq_fire) lirq_pay <= cmd_pay;
        end
    end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SELF_ID   = 2,
    localparam int ID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CNT_W    = $clog2(NUM_CORES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_short,
    input  logic [ID_W-1:0]   cmd_dest,
    input  logic [VEC_W-1:0]  cmd_vector,
    input  logic [MODE_W-1:0] cmd_mode,
    input  logic              cmd_trig,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [ID_W-1:0]   msg_dest,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [MODE_W-1:0] msg_mode,
    output logic              msg_trig,
    input  logic              rsp_valid,
    output logic              lirq_valid,
    output logic [VEC_W-1:0]  lirq_vector,
    output logic [MODE_W-1:0] lirq_mode,
    output logic              lirq_trig,
    output logic              busy,
    output logic              rsp_err
);
    ipi_payload_t cmd_pay, msg_pay, lirq_pay;
    logic         add_one, add_bcast, lirq_fire, cnt_zero;

    assign cmd_pay = '{vector: cmd_vector, mode: cmd_mode, trig: cmd_trig};

    ipi_seq #(.NUM_CORES(NUM_CORES), .SELF_ID(SELF_ID), .ID_W(ID_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_short (short_e'(cmd_short)),
        .cmd_dest  (cmd_dest),
        .cmd_pay   (cmd_pay),
        .msg_ready (msg_ready),
        .cnt_zero  (cnt_zero),
        .cmd_ready (cmd_ready),
        .msg_valid (msg_valid),
        .msg_dest  (msg_dest),
        .msg_pay   (msg_pay),
        .add_one   (add_one),
        .add_bcast (add_bcast),
        .lirq_fire (lirq_fire)
    );

    ipi_inflight #(.NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .add_one   (add_one),
        .add_bcast (add_bcast),
        .rsp_valid (rsp_valid),
        .busy      (busy),
        .cnt_zero  (cnt_zero),
        .rsp_err   (rsp_err)
    );

    ipi_local u_local (
        .clk        (clk),
        .rst_n      (rst_n),
        .lirq_fire  (lirq_fire),
        .cmd_pay    (cmd_pay),
        .lirq_valid (lirq_valid),
        .lirq_pay   (lirq_pay)
    );

    assign msg_vector  = msg_pay.vector;
    assign msg_mode    = msg_pay.mode;
    assign msg_trig    = msg_pay.trig;
    assign lirq_vector = lirq_pay.vector;
    assign lirq_mode   = lirq_pay.mode;
    assign lirq_trig   = lirq_pay.trig;
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
    parameter int NUM_CORES = 4,
    parameter int SELF_ID   = 2,
    parameter int ID_W      = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [1:0]      cmd_short,
    input logic            msg_valid,
    input logic            msg_ready,
    input logic [ID_W-1:0] msg_dest,
    input logic            rsp_valid,
    input logic            lirq_valid,
    input logic            busy,
    input logic            rsp_err
);
    logic accept, bmode;
    assign accept = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n)      bmode <= 1'b0;
        else if (accept) bmode <= cmd_short[1];
    end

    AST_UNI_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_short == 2'd0 && !rsp_valid |=> busy && msg_valid); // R1
    AST_SELF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_short == 2'd1 |=> lirq_valid && !msg_valid && !busy); // R2
    AST_ALL_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        accept && cmd_short == 2'd2 |=> lirq_valid && msg_valid); // R3
    AST_BCAST_SKIP_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && bmode |-> msg_dest != ID_W'(SELF_ID)); // R4
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !busy && !msg_valid); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> rsp_err); // R7
    AST_STRAY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !busy |=> rsp_err); // R7
    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest)); // R9
endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CORES(NUM_CORES), .SELF_ID(SELF_ID), .ID_W(ID_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_short  (cmd_short),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_dest   (msg_dest),
    .rsp_valid  (rsp_valid),
    .lirq_valid (lirq_valid),
    .busy       (busy),
    .rsp_err    (rsp_err)
);

// File: tb/test_ipi_dispatch.sv
module test_ipi_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 4;
    localparam int SELF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_ready;
    logic [1:0] cmd_short = '0, cmd_dest = '0;
    logic [7:0] cmd_vector = '0;
    logic [2:0] cmd_mode = '0;
    logic       cmd_trig = 1'b0;
    logic       msg_valid, msg_ready = 1'b1;
    logic [1:0] msg_dest;
    logic [7:0] msg_vector;
    logic [2:0] msg_mode;
    logic       msg_trig;
    logic       rsp_valid = 1'b0;
    logic       lirq_valid;
    logic [7:0] lirq_vector;
    logic [2:0] lirq_mode;
    logic       lirq_trig;
    logic       busy, rsp_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_dispatch #(.NUM_CORES(N), .SELF_ID(SELF)) i_ipi_dispatch (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_short(cmd_short),
        .cmd_dest(cmd_dest), .cmd_vector(cmd_vector), .cmd_mode(cmd_mode), .cmd_trig(cmd_trig),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
        .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_trig(msg_trig),
        .rsp_valid(rsp_valid),
        .lirq_valid(lirq_valid), .lirq_vector(lirq_vector), .lirq_mode(lirq_mode), .lirq_trig(lirq_trig),
        .busy(busy), .rsp_err(rsp_err)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && !cmd_ready; i++) @(negedge clk);
        chk(cmd_ready, "R6 ready returns", int'(cmd_ready), 1);
    endtask

    // Drives a command at a negedge; returns at the negedge after acceptance.
    task automatic issue(input logic [1:0] sh, input logic [1:0] dst,
                         input logic [7:0] v, input logic [2:0] m, input logic t);
        cmd_valid = 1'b1; cmd_short = sh; cmd_dest = dst;
        cmd_vector = v; cmd_mode = m; cmd_trig = t;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic respond();
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // Expects the broadcast messages in ascending order, skipping SELF.
    task automatic expect_bcast(input logic [7:0] v, input string tag);
        for (int id = 0; id < N; id++) begin
            if (id != SELF) begin
                chk(msg_valid && msg_dest == 2'(id), tag, int'(msg_dest), id);
                chk(msg_vector == v, tag, int'(msg_vector), int'(v));
                @(negedge clk);
            end
        end
        chk(!msg_valid, tag, int'(msg_valid), 0);
    endtask

    task automatic t_reset();
        chk(!busy && !rsp_err, "R8 busy/err", int'({busy, rsp_err}), 0);
        chk(!msg_valid && !lirq_valid, "R8 valids", int'({msg_valid, lirq_valid}), 0);
        chk(cmd_ready, "R8 ready", int'(cmd_ready), 1);
    endtask

    task automatic t_unicast();
        wait_idle();
        issue(2'd0, 2'd3, 8'h41, 3'd0, 1'b0);
        chk(busy, "R1 busy", int'(busy), 1);
        chk(!cmd_ready, "R6 ready low", int'(cmd_ready), 0);
        chk(msg_valid && msg_dest == 2'd3, "R1 dest", int'(msg_dest), 3);
        chk(msg_vector == 8'h41, "R1 vector", int'(msg_vector), 'h41);
        chk(!lirq_valid, "R1 no local", int'(lirq_valid), 0);
        @(negedge clk);
        chk(!msg_valid, "R1 one message", int'(msg_valid), 0);
        chk(busy, "R5 busy before rsp", int'(busy), 1);
        respond();
        chk(!busy, "R5 busy clears", int'(busy), 0);
    endtask

    task automatic t_self();
        wait_idle();
        issue(2'd1, 2'd0, 8'h22, 3'd5, 1'b1);
        chk(lirq_valid, "R2 strobe", int'(lirq_valid), 1);
        chk(lirq_vector == 8'h22 && lirq_mode == 3'd5 && lirq_trig,
            "R2 fields", int'({lirq_vector, lirq_mode, lirq_trig}), int'({8'h22, 3'd5, 1'b1}));
        chk(!msg_valid && !busy, "R2 no message", int'({msg_valid, busy}), 0);
        chk(cmd_ready, "R6 ready after self", int'(cmd_ready), 1);
        @(negedge clk);
        chk(!lirq_valid, "R2 one pulse", int'(lirq_valid), 0);
    endtask

    task automatic t_all_incl();
        wait_idle();
        issue(2'd2, 2'd0, 8'h55, 3'd1, 1'b0);
        chk(lirq_valid && lirq_vector == 8'h55, "R3 local", int'(lirq_vector), 'h55);
        chk(busy, "R3 busy", int'(busy), 1);
        expect_bcast(8'h55, "R3 broadcast");
        respond(); respond();
        chk(busy, "R5 busy after N-2 rsp", int'(busy), 1);
        respond();
        chk(!busy, "R5 busy after N-1 rsp", int'(busy), 0);
    endtask

    task automatic t_all_excl();
        wait_idle();
        msg_ready = 1'b0;
        issue(2'd3, 2'd0, 8'h66, 3'd2, 1'b1);
        chk(!lirq_valid, "R4 no local", int'(lirq_valid), 0);
        chk(msg_valid && msg_dest == 2'd0, "R9 first dest", int'(msg_dest), 0);
        @(negedge clk);
        chk(msg_valid && msg_dest == 2'd0 && msg_vector == 8'h66, "R9 held", int'(msg_dest), 0);
        msg_ready = 1'b1;
        expect_bcast(8'h66, "R4 broadcast");
        respond(); respond();
        chk(busy, "R5 busy pending", int'(busy), 1);
        respond();
        chk(!busy, "R5 busy done", int'(busy), 0);
    endtask

    task automatic t_overlap();
        wait_idle();
        issue(2'd3, 2'd0, 8'h77, 3'd0, 1'b0);
        chk(msg_dest == 2'd0, "R10 dest0", int'(msg_dest), 0);
        @(negedge clk);
        chk(msg_dest == 2'd1, "R10 dest1", int'(msg_dest), 1);
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(msg_valid && msg_dest == 2'd3, "R10 dest3", int'(msg_dest), 3);
        @(negedge clk);
        chk(!msg_valid && busy, "R10 sent, pending", int'({msg_valid, busy}), 1);
        respond();
        chk(busy, "R10 one left", int'(busy), 1);
        respond();
        chk(!busy && !rsp_err, "R10 drained", int'({busy, rsp_err}), 0);
    endtask

    task automatic t_stray();
        wait_idle();
        respond();
        chk(rsp_err, "R7 err set", int'(rsp_err), 1);
        chk(!busy, "R7 busy low", int'(busy), 0);
        issue(2'd0, 2'd1, 8'h10, 3'd0, 1'b0);
        @(negedge clk);
        chk(busy, "R7 count intact", int'(busy), 1);
        respond();
        chk(!busy, "R7 single rsp clears", int'(busy), 0);
        chk(rsp_err, "R7 err sticky", int'(rsp_err), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_self();
        t_all_incl();
        t_all_excl();
        t_overlap();
        t_stray();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule